// File: doc/BRIEF.md
# Latched One-of-Sixteen Line Decoder

This block holds a 4-bit address in a register and decodes it onto sixteen output lines, of which at most one is active at a time. The address register follows the address inputs while the load control is high and keeps its last value while the load control is low. After the register, the address path is purely combinational. The clocked register takes the place of a level-sensitive latch, so the new address shows on the lines one rising clock edge after it is loaded.

A separate gate input is active-low and is not stored. While it is low, the addressed line is active. While it is high, every line sits at its idle level. Because the gate acts on the lines directly, a serial bit stream fed into it reaches only the addressed line, which makes the block a 1-to-16 demultiplexer. The same gate serves as a chip select: decode the upper address bits outside the block and drive the gate of each instance with the result, and several instances form a wider decoder.

An elaboration-time parameter sets the polarity. In one setting the selected line is high and idle lines are low. In the other the selected line is low and idle lines are high. All pins are plain level signals with no handshake, because there is no data stream to pace.

Top module: `latched_line_decoder`

## Requirements
- R1: On a rising clock edge with `load_en` high, the held address takes the value of `sel`. From that edge on, the lines decode the new address.
- R2: While `load_en` is low, changes on `sel`, with or without clock edges, leave the held address and the lines unchanged.
- R3: With `gate_n` low, exactly one line differs from the idle level, and its index equals the held address (`sel[0]` least significant, `sel[3]` most significant).
- R4: With `gate_n` high, all sixteen lines sit at the idle level whatever the address: 0 when `ACTIVE_LOW`=0, 1 when `ACTIVE_LOW`=1.
- R5: With `ACTIVE_LOW`=0 the selected line is 1 and the others are 0. With `ACTIVE_LOW`=1 the selected line is 0 and the others are 1.
- R6: `gate_n` reaches the lines combinationally, without waiting for a clock edge. The addressed line carries `~gate_n` when `ACTIVE_LOW`=0 and `gate_n` when `ACTIVE_LOW`=1, which gives the demultiplexer use.
- R7: An asynchronous reset (`rst_n` low) clears the held address to 0.
- R8: Two instances whose gates are driven by `gate | a[4]` and `gate | ~a[4]`, sharing `a[3:0]`, act as a 32-line decoder. The concatenation {upper, lower} has only bit `a` set when `gate` is low, and is all zeros when `gate` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the address register |
| rst_n | input | 1 | Asynchronous active-low reset; clears the held address |
| load_en | input | 1 | High: register loads `sel` on each rising edge; low: hold |
| sel | input | 4 | Address inputs |
| gate_n | input | 1 | Active-low enable, demux data and chip select; not stored |
| lines | output | 16 | Decoded outputs, polarity set by `ACTIVE_LOW` |

## Verification
The bench sweeps all sixteen addresses with loading enabled, on an instance of each polarity. This separates a correct index and bit order from a swapped or shifted decode, and separates the active level from the idle level. A hold pattern changes `sel` while `load_en` is low, with and without clock edges, so a register that loads regardless of the control shows up. Toggling `gate_n` between clock edges tells a combinational gate apart from a stored one, and confirms the inhibit pattern and the demultiplexed data level. A two-instance cascade is swept over all 32 addresses, which exposes any leak of an active line from the deselected instance.

// File: rtl/ld_pkg.sv
package ld_pkg;
  // Idle level of an output line for a given polarity setting.
  function automatic logic idle_level(input bit active_low);
    return active_low ? 1'b1 : 1'b0;
  endfunction
endpackage

// File: rtl/ld_addr_reg.sv
module ld_addr_reg #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [SEL_W-1:0] sel,
  output logic [SEL_W-1:0] held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= '0;
    else if (load_en) held <= sel;
  end

  AST_LOAD_TAKES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (held == $past(sel))); // R1
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(held)); // R2
endmodule

// File: rtl/ld_onehot.sv
module ld_onehot #(
  parameter int SEL_W = 4,
  localparam int LINES = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] addr,
  output logic [LINES-1:0] hit
);
  for (genvar i = 0; i < LINES; i++) begin : g_hit
    assign hit[i] = (addr == SEL_W'(i));
  end

  always_comb begin
    AST_HIT_ONEHOT: assert ($onehot(hit)); // R3
  end
endmodule

// File: rtl/ld_out_stage.sv
module ld_out_stage #(
  parameter int LINES      = 16,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic [LINES-1:0] hit,
  input  logic             gate_n,
  output logic [LINES-1:0] lines
);
  logic [LINES-1:0] act;
  assign act = hit & {LINES{~gate_n}};

  if (ACTIVE_LOW) begin : g_low
    assign lines = ~act;
  end else begin : g_high
    assign lines = act;
  end
endmodule

// File: rtl/latched_line_decoder.sv
module latched_line_decoder #(
  parameter int SEL_W      = 4,
  parameter bit ACTIVE_LOW = 1'b0,
  localparam int LINES     = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [SEL_W-1:0] sel,
  input  logic             gate_n,
  output logic [LINES-1:0] lines
);
  import ld_pkg::*;

  localparam logic IDLE = idle_level(ACTIVE_LOW);

  logic [SEL_W-1:0] held;
  logic [LINES-1:0] hit;

  ld_addr_reg #(.SEL_W(SEL_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .sel(sel), .held(held)
  );

  ld_onehot #(.SEL_W(SEL_W)) u_dec (
    .addr(held), .hit(hit)
  );

  ld_out_stage #(.LINES(LINES), .ACTIVE_LOW(ACTIVE_LOW)) u_out (
    .hit(hit), .gate_n(gate_n), .lines(lines)
  );

  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_n |-> $onehot(lines ^ {LINES{IDLE}})); // R3
  AST_SELECTED_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_n |-> (lines[held] == ~IDLE)); // R5
  AST_INHIBIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    gate_n |-> (lines == {LINES{IDLE}})); // R4
  AST_RESET_ADDR: assert property (@(posedge clk)
    !rst_n |-> (held == '0)); // R7
endmodule

// File: tb/latched_line_decoder_bench.sv
module latched_line_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_en = 1'b0;
  logic [3:0] sel = '0;
  logic gate_n = 1'b1;
  logic [15:0] lines_h, lines_l;

  logic load_c = 1'b0;
  logic [4:0] a5 = '0;
  logic g_c = 1'b1;
  logic [15:0] lines_c0, lines_c1;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  latched_line_decoder u_latched_line_decoder (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .sel(sel),
    .gate_n(gate_n), .lines(lines_h));

  latched_line_decoder #(.ACTIVE_LOW(1'b1)) u_low (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .sel(sel),
    .gate_n(gate_n), .lines(lines_l));

  latched_line_decoder u_casc_lo (
    .clk(clk), .rst_n(rst_n), .load_en(load_c), .sel(a5[3:0]),
    .gate_n(g_c | a5[4]), .lines(lines_c0));

  latched_line_decoder u_casc_hi (
    .clk(clk), .rst_n(rst_n), .load_en(load_c), .sel(a5[3:0]),
    .gate_n(g_c | ~a5[4]), .lines(lines_c1));

  function automatic logic [15:0] exp_hi(input logic [3:0] a, input logic g);
    return g ? 16'h0000 : (16'h0001 << a);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    gate_n = 1'b0;
    #1;
    chk("R7 reset high", {16'h0, lines_h}, {16'h0, exp_hi(4'd0, 1'b0)});
    chk("R7 reset low", {16'h0, lines_l}, {16'h0, ~exp_hi(4'd0, 1'b0)});
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R7 after release", {16'h0, lines_h}, 32'h1);
  endtask

  task automatic t_sweep();
    gate_n = 1'b0; load_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); sel = 4'(i);
      @(negedge clk);
      chk("R1 R3 sweep high", {16'h0, lines_h}, {16'h0, exp_hi(4'(i), 1'b0)});
      chk("R5 sweep low", {16'h0, lines_l}, {16'h0, ~exp_hi(4'(i), 1'b0)});
    end
  endtask

  task automatic t_hold();
    @(negedge clk); load_en = 1'b1; sel = 4'd5; gate_n = 1'b0;
    @(negedge clk); load_en = 1'b0; sel = 4'd9;
    #1;
    chk("R2 hold no edge", {16'h0, lines_h}, {16'h0, exp_hi(4'd5, 1'b0)});
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); sel = 4'(10 + k);
    end
    @(negedge clk);
    chk("R2 hold after edges", {16'h0, lines_h}, {16'h0, exp_hi(4'd5, 1'b0)});
    chk("R2 hold low pol", {16'h0, lines_l}, {16'h0, ~exp_hi(4'd5, 1'b0)});
  endtask

  task automatic t_inhibit();
    @(negedge clk); gate_n = 1'b1;
    #1;
    chk("R4 inhibit high", {16'h0, lines_h}, 32'h0000);
    chk("R4 inhibit low", {16'h0, lines_l}, 32'hFFFF);
    load_en = 1'b1;
    for (int i = 0; i < 16; i += 5) begin
      @(negedge clk); sel = 4'(i);
      @(negedge clk);
      chk("R4 inhibit any addr", {16'h0, lines_h}, 32'h0000);
      chk("R4 inhibit any addr low", {16'h0, lines_l}, 32'hFFFF);
    end
    load_en = 1'b0;
  endtask

  task automatic t_demux();
    @(negedge clk); load_en = 1'b1; sel = 4'd3;
    @(negedge clk); load_en = 1'b0;
    for (int b = 0; b < 4; b++) begin
      #2 gate_n = b[0];
      #1;
      chk("R6 demux high", {31'h0, lines_h[3]}, {31'h0, ~gate_n});
      chk("R6 demux low", {31'h0, lines_l[3]}, {31'h0, gate_n});
      chk("R6 others idle", {16'h0, lines_h & 16'hFFF7}, 32'h0);
    end
  endtask

  task automatic t_cascade();
    load_c = 1'b1; g_c = 1'b0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); a5 = 5'(i);
      @(negedge clk);
      chk("R8 cascade", {lines_c1, lines_c0}, 32'h1 << i);
    end
    g_c = 1'b1;
    #1;
    chk("R8 cascade inhibit", {lines_c1, lines_c0}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_hold();
    t_inhibit();
    t_demux();
    t_cascade();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule